// File: doc/BRIEF.md
# Interlace-Aware Video Sync Timing Generator

This block produces the raster reference signals for a video pipeline from a free-running pixel counter and line counter: a horizontal active-window strobe, a vertical blanking strobe, a vertical sync pulse and a field indicator. A byte-wide, write-only register port sets every edge position and the raster totals. The block supports interlaced video, where each field has its own vertical blanking region and vertical sync pulse, and progressive video, which is selected when all field-2 line settings are zero.

Register writes land in a shadow set. The shadow set is copied into the active set on the clock edge that ends a frame, so a frame never mixes old and new settings. Every output is a register. Each one is computed from the next-state counter values, so in any cycle the outputs match the counter position of that same cycle.

Top module: `sync_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `href`, `vref`, `vs` and `field_id` are low. The pixel and line counters return to position 1 and 1, and the shadow and active settings return to their defaults.
- R2: The pixel position runs from 1 up to the pixels-per-line total and then wraps to 1. The line position advances by one at each wrap, and after the lines-per-frame total it wraps to 1. The pixels-per-line total is {reg 16 bits 3:0, reg 15}; the lines-per-frame total is {reg 18 bits 2:0, reg 17}. After reset they take the parameter values `RST_PPL` and `RST_LPF`.
- R3: `href` is high exactly when the pixel position P satisfies start <= P < end. Start is {reg 1 bits 7:4, reg 0} and end is {reg 1 bits 3:0, reg 2}. If start >= end, `href` stays low.
- R4: `vref` is high on lines L with s1 <= L < s1+w1. It is also high, when interlaced, on lines with s2 <= L < s2+w2. Here s1 = {reg 10 bits 2:0, reg 9}, w1 = reg 11, s2 = {reg 13 bits 2:0, reg 12} and w2 = reg 14. `vref` changes only in a cycle where the pixel position is 1.
- R5: `vs` is high only on the first line of the current field's vertical region (s1 in field 1, s2 in field 2), for pixel positions with start <= P < end. Field-1 start is {reg 4 bits 7:4, reg 3} and its end is {reg 4 bits 3:0, reg 5}. Field-2 start is {reg 7 bits 7:4, reg 6} and its end is {reg 7 bits 3:0, reg 8}.
- R6: If the current field's sync start or end position is 0, `vs` stays low for that whole field.
- R7: The video is progressive when s2 = 0 and w2 = 0. In progressive mode, `field_id` stays 0 and the field-2 vertical region and field-2 sync pulse have no effect.
- R8: When interlaced and s2 is nonzero, `field_id` is 1 (field 2) on lines L >= s2 and 0 on the lines before s2. It therefore returns to 0 at line 1 of every frame and changes only at pixel position 1.
- R9: A register write takes effect only from the first pixel of the next frame. Until then, every output follows the settings that were active when the frame began.
- R10: After reset, registers 0, 2, 3, 5, 6 and 8 read as 01h and registers 1, 4 and 7 read as 00h. A write to address 19 or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| href | output | 1 | High inside the horizontal active window |
| vref | output | 1 | High during vertical blanking |
| vs | output | 1 | Vertical sync pulse |
| field_id | output | 1 | 0 for field 1, 1 for field 2 |

## Verification
The assertions assume that the pixels-per-line and lines-per-frame totals are at least 2. They also assume that no write arrives on the very edge that ends a frame; on that edge the active set takes the shadow value as it stood before the write. The stimulus keeps the totals at small values of 12/10 and 9/7, so each setting is checked over every pixel of whole frames. Each write is delayed by one cycle when the next edge would close a frame. Settings are only programmed with field-2 regions that lie inside the frame.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    localparam int PIX_W = 12;
    localparam int LIN_W = 11;
    localparam int WID_W = 8;
    localparam int ADR_W = 5;
    localparam int BYTE_W = 8;
    localparam int PIX_HI = PIX_W - BYTE_W;
    localparam int LIN_HI = LIN_W - BYTE_W;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [LIN_W-1:0] lin_t;
    typedef logic [WID_W-1:0] wid_t;

    typedef enum logic [ADR_W-1:0] {
        A_HACT_S_LO = 5'd0,
        A_HACT_NIB  = 5'd1,
        A_HACT_E_LO = 5'd2,
        A_SY1_S_LO  = 5'd3,
        A_SY1_NIB   = 5'd4,
        A_SY1_E_LO  = 5'd5,
        A_SY2_S_LO  = 5'd6,
        A_SY2_NIB   = 5'd7,
        A_SY2_E_LO  = 5'd8,
        A_BL1_LO    = 5'd9,
        A_BL1_HI    = 5'd10,
        A_BL1_WID   = 5'd11,
        A_BL2_LO    = 5'd12,
        A_BL2_HI    = 5'd13,
        A_BL2_WID   = 5'd14,
        A_PPL_LO    = 5'd15,
        A_PPL_HI    = 5'd16,
        A_LPF_LO    = 5'd17,
        A_LPF_HI    = 5'd18
    } reg_addr_e;

    typedef struct packed {
        pix_t hact_s;
        pix_t hact_e;
        pix_t sy1_s;
        pix_t sy1_e;
        pix_t sy2_s;
        pix_t sy2_e;
        lin_t bl1_line;
        wid_t bl1_wid;
        lin_t bl2_line;
        wid_t bl2_wid;
        pix_t ppl;
        lin_t lpf;
    } timing_cfg_t;

    function automatic logic in_span(input pix_t pos, input pix_t s, input pix_t e);
        return (pos >= s) && (pos < e);
    endfunction

    function automatic logic in_lines(input lin_t ln, input lin_t st, input wid_t w);
        logic [LIN_W:0] stop;
        stop = {1'b0, st} + {{(LIN_W + 1 - WID_W){1'b0}}, w};
        return (ln >= st) && ({1'b0, ln} < stop);
    endfunction

    function automatic logic is_interlaced(input timing_cfg_t c);
        return (c.bl2_line != '0) || (c.bl2_wid != '0);
    endfunction

    function automatic timing_cfg_t cfg_default(input pix_t ppl, input lin_t lpf);
        timing_cfg_t c;
        c = '0;
        c.hact_s = pix_t'(1);
        c.hact_e = pix_t'(1);
        c.sy1_s  = pix_t'(1);
        c.sy1_e  = pix_t'(1);
        c.sy2_s  = pix_t'(1);
        c.sy2_e  = pix_t'(1);
        c.ppl    = ppl;
        c.lpf    = lpf;
        return c;
    endfunction

endpackage

// File: rtl/vsg_regs.sv
module vsg_regs
    import vsg_pkg::*;
#(
    parameter int RST_PPL = 2200,
    parameter int RST_LPF = 1125
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADR_W-1:0]    wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                frame_end,
    output timing_cfg_t         cfg_act,
    output timing_cfg_t         cfg_nxt
);

    localparam timing_cfg_t DEF = cfg_default(pix_t'(RST_PPL), lin_t'(RST_LPF));

    timing_cfg_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= DEF;
        end else if (wr_en) begin
            case (wr_addr)
                A_HACT_S_LO: shadow.hact_s[BYTE_W-1:0] <= wr_data;
                A_HACT_E_LO: shadow.hact_e[BYTE_W-1:0] <= wr_data;
                A_HACT_NIB: begin
                    shadow.hact_s[PIX_W-1:BYTE_W] <= wr_data[7:4];
                    shadow.hact_e[PIX_W-1:BYTE_W] <= wr_data[3:0];
                end
                A_SY1_S_LO:  shadow.sy1_s[BYTE_W-1:0] <= wr_data;
                A_SY1_E_LO:  shadow.sy1_e[BYTE_W-1:0] <= wr_data;
                A_SY1_NIB: begin
                    shadow.sy1_s[PIX_W-1:BYTE_W] <= wr_data[7:4];
                    shadow.sy1_e[PIX_W-1:BYTE_W] <= wr_data[3:0];
                end
                A_SY2_S_LO:  shadow.sy2_s[BYTE_W-1:0] <= wr_data;
                A_SY2_E_LO:  shadow.sy2_e[BYTE_W-1:0] <= wr_data;
                A_SY2_NIB: begin
                    shadow.sy2_s[PIX_W-1:BYTE_W] <= wr_data[7:4];
                    shadow.sy2_e[PIX_W-1:BYTE_W] <= wr_data[3:0];
                end
                A_BL1_LO:  shadow.bl1_line[BYTE_W-1:0] <= wr_data;
                A_BL1_HI:  shadow.bl1_line[LIN_W-1:BYTE_W] <= wr_data[LIN_HI-1:0];
                A_BL1_WID: shadow.bl1_wid <= wr_data;
                A_BL2_LO:  shadow.bl2_line[BYTE_W-1:0] <= wr_data;
                A_BL2_HI:  shadow.bl2_line[LIN_W-1:BYTE_W] <= wr_data[LIN_HI-1:0];
                A_BL2_WID: shadow.bl2_wid <= wr_data;
                A_PPL_LO:  shadow.ppl[BYTE_W-1:0] <= wr_data;
                A_PPL_HI:  shadow.ppl[PIX_W-1:BYTE_W] <= wr_data[PIX_HI-1:0];
                A_LPF_LO:  shadow.lpf[BYTE_W-1:0] <= wr_data;
                A_LPF_HI:  shadow.lpf[LIN_W-1:BYTE_W] <= wr_data[LIN_HI-1:0];
                default: ;
            endcase
        end
    end

    assign cfg_nxt = frame_end ? shadow : cfg_act;

    always_ff @(posedge clk) begin
        if (rst) cfg_act <= DEF;
        else     cfg_act <= cfg_nxt;
    end

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(cfg_act));

endmodule

// File: rtl/vsg_counter.sv
module vsg_counter
    import vsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pix_t  ppl,
    input  lin_t  lpf,
    output pix_t  pix,
    output lin_t  line,
    output pix_t  pix_nx,
    output lin_t  line_nx,
    output logic  frame_end
);

    logic line_end;

    assign line_end  = (pix >= ppl);
    assign frame_end = line_end && (line >= lpf);

    always_comb begin
        pix_nx  = line_end ? pix_t'(1) : pix + pix_t'(1);
        line_nx = line;
        if (line_end) line_nx = (line >= lpf) ? lin_t'(1) : line + lin_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix  <= pix_t'(1);
            line <= lin_t'(1);
        end else begin
            pix  <= pix_nx;
            line <= line_nx;
        end
    end

    // R2
    pix_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (pix == pix_t'(1)));

    // R2
    line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (line == lin_t'(1)));

endmodule

// File: rtl/vsg_outputs.sv
module vsg_outputs
    import vsg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  timing_cfg_t  cfg,
    input  pix_t         pix_nx,
    input  lin_t         line_nx,
    input  pix_t         pix,
    output logic         href,
    output logic         vref,
    output logic         vs,
    output logic         field_id
);

    logic ilace, fld_n, href_n, vref_n, vs_n;
    pix_t sy_s, sy_e;
    lin_t sy_line;

    always_comb begin
        ilace   = is_interlaced(cfg);
        fld_n   = ilace && (cfg.bl2_line != '0) && (line_nx >= cfg.bl2_line);
        href_n  = in_span(pix_nx, cfg.hact_s, cfg.hact_e);
        vref_n  = in_lines(line_nx, cfg.bl1_line, cfg.bl1_wid)
               || (ilace && in_lines(line_nx, cfg.bl2_line, cfg.bl2_wid));
        sy_s    = fld_n ? cfg.sy2_s    : cfg.sy1_s;
        sy_e    = fld_n ? cfg.sy2_e    : cfg.sy1_e;
        sy_line = fld_n ? cfg.bl2_line : cfg.bl1_line;
        vs_n    = (sy_s != '0) && (sy_e != '0) && (line_nx == sy_line)
               && in_span(pix_nx, sy_s, sy_e);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            href     <= 1'b0;
            vref     <= 1'b0;
            vs       <= 1'b0;
            field_id <= 1'b0;
        end else begin
            href     <= href_n;
            vref     <= vref_n;
            vs       <= vs_n;
            field_id <= fld_n;
        end
    end

    // R4
    vref_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(vref) |-> (pix == pix_t'(1)));

    // R8
    field_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(field_id) |-> (pix == pix_t'(1)));

endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen
    import vsg_pkg::*;
#(
    parameter int RST_PPL = 2200,
    parameter int RST_LPF = 1125
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              href,
    output logic              vref,
    output logic              vs,
    output logic              field_id
);

    timing_cfg_t cfg_act, cfg_nxt;
    pix_t pix, pix_nx;
    lin_t line, line_nx;
    logic frame_end;

    vsg_regs #(.RST_PPL(RST_PPL), .RST_LPF(RST_LPF)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_end(frame_end),
        .cfg_act(cfg_act), .cfg_nxt(cfg_nxt)
    );

    vsg_counter u_cnt (
        .clk(clk), .rst(rst), .ppl(cfg_act.ppl), .lpf(cfg_act.lpf),
        .pix(pix), .line(line), .pix_nx(pix_nx), .line_nx(line_nx),
        .frame_end(frame_end)
    );

    vsg_outputs u_out (
        .clk(clk), .rst(rst), .cfg(cfg_nxt), .pix_nx(pix_nx),
        .line_nx(line_nx), .pix(pix), .href(href), .vref(vref),
        .vs(vs), .field_id(field_id)
    );

    // R7
    prog_field_chk: assert property (@(posedge clk) disable iff (rst)
        !is_interlaced(cfg_act) |-> !field_id);

    // R6
    vs_off_chk: assert property (@(posedge clk) disable iff (rst)
        vs |-> (field_id ? (cfg_act.sy2_s != '0 && cfg_act.sy2_e != '0)
                         : (cfg_act.sy1_s != '0 && cfg_act.sy1_e != '0)));

    // R5
    vs_line_chk: assert property (@(posedge clk) disable iff (rst)
        vs |-> (line == (field_id ? cfg_act.bl2_line : cfg_act.bl1_line)));

endmodule

// File: tb/sync_timing_gen_tb.sv
module sync_timing_gen_tb;

    localparam int PPL = 12;
    localparam int LPF = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       href, vref, vs, field_id;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] shb [19];
    logic [7:0] actb [19];
    int mpx, mln;
    string tag;

    sync_timing_gen #(.RST_PPL(PPL), .RST_LPF(LPF)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .href(href), .vref(vref), .vs(vs),
        .field_id(field_id)
    );

    always #2 clk = ~clk;

    function automatic int pos(input logic [7:0] lo, input logic [7:0] nib, input bit upper);
        return upper ? int'({nib[7:4], lo}) : int'({nib[3:0], lo});
    endfunction

    function automatic int a_ppl();
        return int'({actb[16][3:0], actb[15]});
    endfunction

    function automatic int a_lpf();
        return int'({actb[18][2:0], actb[17]});
    endfunction

    task automatic cmp(input string req, input string nm, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s at pix %0d line %0d: got %0b expected %0b",
                     req, tag, nm, mpx, mln, got, exp);
        end
    endtask

    task automatic check_out();
        int hs, he, s1s, s1e, s2s, s2e, b1, w1, b2, w2, ss, se, vl;
        bit il, f, eh, ev, es;
        hs  = pos(actb[0], actb[1], 1'b1);
        he  = pos(actb[2], actb[1], 1'b0);
        s1s = pos(actb[3], actb[4], 1'b1);
        s1e = pos(actb[5], actb[4], 1'b0);
        s2s = pos(actb[6], actb[7], 1'b1);
        s2e = pos(actb[8], actb[7], 1'b0);
        b1  = int'({actb[10][2:0], actb[9]});
        w1  = int'(actb[11]);
        b2  = int'({actb[13][2:0], actb[12]});
        w2  = int'(actb[14]);
        il  = (b2 != 0) || (w2 != 0);
        f   = il && (b2 != 0) && (mln >= b2);
        eh  = (mpx >= hs) && (mpx < he);
        ev  = ((mln >= b1) && (mln < b1 + w1)) || (il && (mln >= b2) && (mln < b2 + w2));
        ss  = f ? s2s : s1s;
        se  = f ? s2e : s1e;
        vl  = f ? b2 : b1;
        es  = (ss != 0) && (se != 0) && (mln == vl) && (mpx >= ss) && (mpx < se);
        cmp("R2/R3", "href", href, eh);
        cmp("R4", "vref", vref, ev);
        cmp("R5/R6", "vs", vs, es);
        cmp("R8/R7", "field_id", field_id, f);
    endtask

    task automatic step();
        bit fe;
        int op, ol;
        op = a_ppl();
        ol = a_lpf();
        fe = (mpx == op) && (mln == ol);
        @(posedge clk);
        if (fe) for (int i = 0; i < 19; i++) actb[i] = shb[i];
        if (wr_en && wr_addr < 5'd19) shb[wr_addr] = wr_data;
        if (mpx >= op) begin
            mpx = 1;
            mln = (mln >= ol) ? 1 : mln + 1;
        end else begin
            mpx = mpx + 1;
        end
        #1;
        check_out();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input int a, input int d);
        if (mpx == a_ppl() && mln == a_lpf()) step();
        wr_en   = 1'b1;
        wr_addr = 5'(a);
        wr_data = 8'(d);
        step();
        wr_en   = 1'b0;
    endtask

    task automatic frames(input int n);
        run(n * a_ppl() * a_lpf() + 3);
    endtask

    initial begin
        for (int i = 0; i < 19; i++) shb[i] = 8'h00;
        shb[0] = 8'h01; shb[2] = 8'h01; shb[3] = 8'h01;
        shb[5] = 8'h01; shb[6] = 8'h01; shb[8] = 8'h01;
        shb[15] = 8'(PPL); shb[16] = 8'(PPL >> 8);
        shb[17] = 8'(LPF); shb[18] = 8'(LPF >> 8);
        for (int i = 0; i < 19; i++) actb[i] = shb[i];
        mpx = 1;
        mln = 1;

        // R1: outputs low while reset is held
        tag = "R1 reset";
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            cmp("R1", "href", href, 1'b0);
            cmp("R1", "vref", vref, 1'b0);
            cmp("R1", "vs", vs, 1'b0);
            cmp("R1", "field_id", field_id, 1'b0);
        end
        rst = 1'b0;

        // R10: defaults keep every output low for a whole frame
        tag = "R10 defaults";
        frames(1);

        // R9: interlaced settings written mid-frame, applied at next frame
        tag = "R9 shadow";
        run(17);
        wr(0, 3); wr(2, 9); wr(1, 8'h00);
        wr(9, 1); wr(10, 0); wr(11, 2);
        wr(12, 6); wr(13, 0); wr(14, 2);
        wr(3, 4); wr(5, 7); wr(4, 8'h00);
        wr(6, 2); wr(8, 5); wr(7, 8'h00);
        wr(25, 8'hff);
        frames(1);

        // R8: interlaced running, both fields
        tag = "R8 interlaced";
        frames(2);

        // R6: zero sync end disables field-1 pulse; zero start on field 2
        tag = "R6 vs-off";
        wr(5, 0);
        frames(1);
        wr(5, 7); wr(6, 0);
        frames(1);
        wr(6, 2);

        // R10: upper nibble placement (end = 0x102 makes href run to line end)
        tag = "R10 nibble";
        wr(2, 2); wr(1, 8'h01);
        frames(2);
        wr(1, 8'h10);
        frames(1);
        wr(1, 8'h00); wr(2, 9);

        // R2: new raster totals
        tag = "R2 totals";
        wr(15, 9); wr(17, 7); wr(12, 4);
        frames(2);

        // R7: progressive mode, field-2 settings zero
        tag = "R7 progressive";
        wr(12, 0); wr(14, 0);
        frames(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule